// File: doc/BRIEF.md
# Configuration Memory Image Validator

This block checks a configuration memory image before any of its fields are trusted. It reads the image one 16-bit word at a time through a simple request/valid port and runs a CRC8 over the bytes. It compares the result with the check byte stored in the high half of the image's final word, whose low half holds the layout revision. The block first tries the short 64-word layout. If that check fails, it re-reads the image from word 0 and tries the long 220-word layout.

After a start pulse the block works on its own until it raises a one-cycle done pulse. At that point it reports four results: whether a layout matched, which layout size was tried last, the revision byte, and the CRC it computed. The results stay unchanged until the next accepted start, which clears them. Unprogrammed memory reads back as 0xFFFF. Such an image is handled like any other, and normally fails both checks.

Top module: `evl_image_check`

## Requirements
- R1: Reset state. After reset, done_o, valid_o, large_o and rd_req_o are 0, and rev_o and crc_o are 0x00.
- R2: Reads. The block issues one word read at a time. It holds rd_req_o high with a stable rd_addr_o until it samples rd_valid_i, and it takes rd_data_i in that same cycle. Within a pass, words are read in ascending order from word address 0, and the next request follows only after both bytes of the current word have entered the CRC.
- R3: CRC arithmetic. The register is seeded with 0xFF at the start of each pass. Bits are shifted in LSB-first through the reflected form (0xAB) of the polynomial x^8+x^7+x^6+x^4+x^2+1. Within each word, bits 7-0 enter before bits 15-8. The computed value is the register XOR 0xFF.
- R4: Short pass. Words 0..63 are covered, with all bytes included except bits 15-8 of word 63. On a match with those bits, the result is valid_o=1, large_o=0 and rev_o = word 63 bits 7-0.
- R5: Long pass. This pass runs only when the short pass fails. It covers words 0..219, with all bytes included except bits 15-8 of word 219. On a match, the result is valid_o=1, large_o=1 and rev_o = word 219 bits 7-0.
- R6: When both passes fail, the result is valid_o=0, large_o=1 and rev_o=0x00.
- R7: crc_o holds the computed CRC of the last pass run.
- R8: Each word takes 3 cycles plus the cycles rd_req_o waits for rd_valid_i. done_o rises N*(3+L) cycles after the edge that accepted start, where N is 64 for a short-pass result or 284 otherwise, and L is a constant memory wait.
- R9: A start pulse while the block is busy is ignored. It does not change the sequence, the timing or the result.
- R10: done_o is high for exactly one cycle. valid_o, large_o, rev_o and crc_o hold until an accepted start, which clears them to 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; sampled only when idle |
| rd_req_o | output | 1 | Word read request |
| rd_addr_o | output | 8 | Word address (byte offset / 2) |
| rd_data_i | input | 16 | Read data, taken when rd_valid_i is high |
| rd_valid_i | input | 1 | Read data valid |
| done_o | output | 1 | One-cycle completion pulse |
| valid_o | output | 1 | A layout's check byte matched |
| large_o | output | 1 | Result comes from the 220-word pass |
| rev_o | output | 8 | Layout revision byte, 0 when invalid |
| crc_o | output | 8 | Computed CRC of the last pass |

## Verification
The done pulse is due N*(3+L) cycles after the accepting edge: 192 cycles for a short-pass result with an immediate memory, and 852 cycles when the long pass runs. The bench counts whole clock edges from the accepting edge and samples every output at the falling edge, so each count is compared exactly against the expected number. The cleared results are checked one cycle after the accepting edge. The done width is checked on the cycle after the pulse, and the held values are checked ten cycles later.

// File: rtl/evl_pkg.sv
package evl_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_FETCH,
    SQ_LOW,
    SQ_HIGH,
    SQ_JUDGE
  } sq_state_e;

  function automatic logic [7:0] bitrev8(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

  // One byte through a reflected (LSB-first) CRC8 register.
  function automatic logic [7:0] crc8_lsb_step(input logic [7:0] crc,
                                               input logic [7:0] din,
                                               input logic [7:0] poly_rev);
    logic [7:0] c;
    logic       fb;
    c = crc;
    for (int i = 0; i < 8; i++) begin
      fb = c[0] ^ din[i];
      c  = c >> 1;
      if (fb) c = c ^ poly_rev;
    end
    return c;
  endfunction

  // One byte through a normal (MSB-first) CRC8 register.
  function automatic logic [7:0] crc8_msb_step(input logic [7:0] crc,
                                               input logic [7:0] din,
                                               input logic [7:0] poly);
    logic [7:0] c;
    logic       fb;
    c = crc;
    for (int i = 7; i >= 0; i--) begin
      fb = c[7] ^ din[i];
      c  = c << 1;
      if (fb) c = c ^ poly;
    end
    return c;
  endfunction

endpackage

// File: rtl/evl_crc8.sv
module evl_crc8 import evl_pkg::*; #(
  parameter logic [7:0] POLY      = 8'hD5,
  parameter logic [7:0] SEED      = 8'hFF,
  parameter logic [7:0] XOR_OUT   = 8'hFF,
  parameter bit         LSB_FIRST = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       init_i,
  input  logic       en_i,
  input  logic [7:0] byte_i,
  output logic [7:0] crc_fin_o
);

  localparam logic [7:0] POLY_REV = bitrev8(POLY);

  logic [7:0] crc_q;
  logic [7:0] crc_nxt;

  generate
    if (LSB_FIRST) begin : g_lsb
      always_comb crc_nxt = crc8_lsb_step(crc_q, byte_i, POLY_REV);
    end else begin : g_msb
      always_comb crc_nxt = crc8_msb_step(crc_q, byte_i, POLY);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= SEED;
    else if (init_i) crc_q <= SEED;
    else if (en_i)   crc_q <= crc_nxt;
  end

  assign crc_fin_o = crc_q ^ XOR_OUT;

  // R3
  crc_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_i |=> (crc_fin_o == (SEED ^ XOR_OUT)));

  // R3
  crc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_i && !en_i) |=> $stable(crc_fin_o));

endmodule

// File: rtl/evl_sequencer.sv
module evl_sequencer import evl_pkg::*; #(
  parameter int SHORT_WORDS = 64,
  parameter int LONG_WORDS  = 220,
  parameter int ADDR_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [15:0]       rd_data_i,
  input  logic              rd_valid_i,
  input  logic              match_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              byte_en_o,
  output logic [7:0]        byte_o,
  output logic              crc_init_o,
  output logic              accept_ev_o,
  output logic              finish_ev_o,
  output logic              long_pass_o,
  output logic [15:0]       word_o
);

  localparam logic [ADDR_W-1:0] SHORT_LAST = ADDR_W'(SHORT_WORDS - 1);
  localparam logic [ADDR_W-1:0] LONG_LAST  = ADDR_W'(LONG_WORDS - 1);

  sq_state_e         state_q;
  logic [ADDR_W-1:0] widx_q;
  logic              long_q;
  logic [15:0]       word_q;
  logic [ADDR_W-1:0] last_idx;
  logic              at_last;
  logic              retry_ev;

  assign last_idx    = long_q ? LONG_LAST : SHORT_LAST;
  assign at_last     = (widx_q == last_idx);
  assign accept_ev_o = (state_q == SQ_IDLE) && start_i;
  assign retry_ev    = (state_q == SQ_JUDGE) && !match_i && !long_q;
  assign finish_ev_o = (state_q == SQ_JUDGE) && (match_i || long_q);
  assign crc_init_o  = accept_ev_o || retry_ev;
  assign byte_en_o   = (state_q == SQ_LOW) || (state_q == SQ_HIGH);
  assign byte_o      = (state_q == SQ_HIGH) ? word_q[15:8] : word_q[7:0];
  assign rd_req_o    = (state_q == SQ_FETCH);
  assign rd_addr_o   = widx_q;
  assign long_pass_o = long_q;
  assign word_o      = word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      widx_q  <= '0;
      long_q  <= 1'b0;
      word_q  <= '0;
    end else begin
      case (state_q)
        SQ_IDLE: begin
          if (start_i) begin
            state_q <= SQ_FETCH;
            widx_q  <= '0;
            long_q  <= 1'b0;
          end
        end
        SQ_FETCH: begin
          if (rd_valid_i) begin
            word_q  <= rd_data_i;
            state_q <= SQ_LOW;
          end
        end
        SQ_LOW:  state_q <= at_last ? SQ_JUDGE : SQ_HIGH;
        SQ_HIGH: begin
          widx_q  <= widx_q + 1'b1;
          state_q <= SQ_FETCH;
        end
        SQ_JUDGE: begin
          if (retry_ev) begin
            long_q  <= 1'b1;
            widx_q  <= '0;
            state_q <= SQ_FETCH;
          end else begin
            state_q <= SQ_IDLE;
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  // R2
  fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && !rd_valid_i) |=> (rd_req_o && $stable(rd_addr_o)));

  // R2
  fetch_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && rd_valid_i) |=> !rd_req_o);

  // R4
  short_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && !long_q) |-> (rd_addr_o <= SHORT_LAST));

  // R5
  long_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |-> (rd_addr_o <= LONG_LAST));

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && (state_q inside {SQ_FETCH, SQ_LOW, SQ_HIGH}))
      |=> (widx_q >= $past(widx_q)));

endmodule

// File: rtl/evl_result.sv
module evl_result #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  logic              finish_i,
  input  logic              long_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [7:0]        crc_fin_i,
  output logic              match_o,
  output logic              done_o,
  output logic              valid_o,
  output logic              large_o,
  output logic [7:0]        rev_o,
  output logic [7:0]        crc_o
);

  localparam int HI_LSB = WORD_W - 8;

  assign match_o = (crc_fin_i == word_i[WORD_W-1:HI_LSB]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o  <= 1'b0;
      valid_o <= 1'b0;
      large_o <= 1'b0;
      rev_o   <= '0;
      crc_o   <= '0;
    end else begin
      done_o <= finish_i;
      if (accept_i) begin
        valid_o <= 1'b0;
        large_o <= 1'b0;
        rev_o   <= '0;
        crc_o   <= '0;
      end else if (finish_i) begin
        valid_o <= match_o;
        large_o <= long_i;
        rev_o   <= match_o ? word_i[7:0] : 8'h00;
        crc_o   <= crc_fin_i;
      end
    end
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R6
  fail_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !valid_o) |-> (large_o && (rev_o == 8'h00)));

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept_i && !finish_i) |=> ($stable(valid_o) && $stable(large_o) &&
                                  $stable(rev_o) && $stable(crc_o)));

endmodule

// File: rtl/evl_image_check.sv
module evl_image_check import evl_pkg::*; #(
  parameter int         SHORT_WORDS = 64,
  parameter int         LONG_WORDS  = 220,
  parameter logic [7:0] CRC_POLY    = 8'hD5,
  parameter logic [7:0] CRC_SEED    = 8'hFF,
  parameter logic [7:0] CRC_XOROUT  = 8'hFF,
  parameter bit         LSB_FIRST   = 1'b1,
  parameter int         ADDR_W      = $clog2(LONG_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [15:0]       rd_data_i,
  input  logic              rd_valid_i,
  output logic              done_o,
  output logic              valid_o,
  output logic              large_o,
  output logic [7:0]        rev_o,
  output logic [7:0]        crc_o
);

  localparam int WORD_W = 16;

  logic              byte_en;
  logic [7:0]        byte_val;
  logic              crc_init;
  logic              accept_ev;
  logic              finish_ev;
  logic              long_pass;
  logic [WORD_W-1:0] word_cur;
  logic [7:0]        crc_fin;
  logic              match;

  evl_sequencer #(
    .SHORT_WORDS(SHORT_WORDS),
    .LONG_WORDS (LONG_WORDS),
    .ADDR_W     (ADDR_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .rd_data_i  (rd_data_i),
    .rd_valid_i (rd_valid_i),
    .match_i    (match),
    .rd_req_o   (rd_req_o),
    .rd_addr_o  (rd_addr_o),
    .byte_en_o  (byte_en),
    .byte_o     (byte_val),
    .crc_init_o (crc_init),
    .accept_ev_o(accept_ev),
    .finish_ev_o(finish_ev),
    .long_pass_o(long_pass),
    .word_o     (word_cur)
  );

  evl_crc8 #(
    .POLY     (CRC_POLY),
    .SEED     (CRC_SEED),
    .XOR_OUT  (CRC_XOROUT),
    .LSB_FIRST(LSB_FIRST)
  ) u_crc (
    .clk      (clk),
    .rst_n    (rst_n),
    .init_i   (crc_init),
    .en_i     (byte_en),
    .byte_i   (byte_val),
    .crc_fin_o(crc_fin)
  );

  evl_result #(
    .WORD_W(WORD_W)
  ) u_res (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept_i (accept_ev),
    .finish_i (finish_ev),
    .long_i   (long_pass),
    .word_i   (word_cur),
    .crc_fin_i(crc_fin),
    .match_o  (match),
    .done_o   (done_o),
    .valid_o  (valid_o),
    .large_o  (large_o),
    .rev_o    (rev_o),
    .crc_o    (crc_o)
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> !rd_req_o);

endmodule

// File: tb/tb_evl_image_check.sv
`timescale 1ns/1ps
module tb_evl_image_check;

  localparam int SW = 64;
  localparam int LW = 220;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic        rd_req_o;
  logic [7:0]  rd_addr_o;
  logic [15:0] rd_data_i;
  logic        rd_valid_i;
  logic        done_o, valid_o, large_o;
  logic [7:0]  rev_o, crc_o;

  logic [15:0] mem [0:255];
  int mem_lat;
  int order_err;
  int exp_addr;
  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  evl_image_check dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
    .rd_data_i(rd_data_i), .rd_valid_i(rd_valid_i),
    .done_o(done_o), .valid_o(valid_o), .large_o(large_o),
    .rev_o(rev_o), .crc_o(crc_o)
  );

  // memory responder: data arrives after mem_lat waiting cycles
  initial begin
    int cnt;
    cnt = 0;
    rd_valid_i = 1'b0;
    rd_data_i  = 16'h0;
    forever begin
      @(negedge clk);
      if (rd_req_o) begin
        if (cnt == mem_lat) begin
          rd_valid_i = 1'b1;
          rd_data_i  = mem[rd_addr_o];
          if (int'(rd_addr_o) != exp_addr && rd_addr_o != 8'd0) order_err++;
          exp_addr = int'(rd_addr_o) + 1;
          cnt = 0;
        end else begin
          rd_valid_i = 1'b0;
          cnt++;
        end
      end else begin
        rd_valid_i = 1'b0;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // bit-serial reference: bytes of words 0..n-1, low byte then high,
  // the high byte of word n-1 left out
  function automatic logic [7:0] ref_crc(input int n);
    logic [7:0] c;
    logic [15:0] w;
    int nb;
    c = 8'hFF;
    for (int k = 0; k < n; k++) begin
      w  = mem[k];
      nb = (k == n - 1) ? 8 : 16;
      for (int b = 0; b < nb; b++) begin
        if (c[0] ^ w[b]) c = (c >> 1) ^ 8'hAB;
        else             c = c >> 1;
      end
    end
    return c ^ 8'hFF;
  endfunction

  task automatic fill(input logic [15:0] seed);
    for (int k = 0; k < 256; k++) mem[k] = 16'(k * 16'h2F1B) ^ seed;
  endtask

  task automatic seal_short(input logic [7:0] rev);
    mem[SW-1][7:0]  = rev;
    mem[SW-1][15:8] = ref_crc(SW);
  endtask

  task automatic seal_long(input logic [7:0] rev);
    mem[SW-1][15:8] = ref_crc(SW) ^ 8'h5A;
    mem[LW-1][7:0]  = rev;
    mem[LW-1][15:8] = ref_crc(LW);
  endtask

  task automatic run_image(input string name, input int lat, input int mid_start);
    logic [7:0] rs, rl, e_rev, e_crc;
    bit s_ok, l_ok, e_valid, e_large;
    int e_cyc, n;
    string tag;
    rs = ref_crc(SW);
    rl = ref_crc(LW);
    s_ok = (rs == mem[SW-1][15:8]);
    l_ok = (rl == mem[LW-1][15:8]);
    if (s_ok) begin
      e_valid = 1; e_large = 0; e_rev = mem[SW-1][7:0]; e_crc = rs;
      e_cyc = SW * (3 + lat); tag = "R4";
    end else if (l_ok) begin
      e_valid = 1; e_large = 1; e_rev = mem[LW-1][7:0]; e_crc = rl;
      e_cyc = (SW + LW) * (3 + lat); tag = "R5";
    end else begin
      e_valid = 0; e_large = 1; e_rev = 8'h00; e_crc = rl;
      e_cyc = (SW + LW) * (3 + lat); tag = "R6";
    end
    mem_lat = lat;
    order_err = 0;
    exp_addr = 0;
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    n = 0;
    // R10: results cleared one cycle after the accepting edge
    check(!valid_o && !large_o && rev_o == 0 && crc_o == 0 && !done_o, "R10",
          {name, " cleared"}, {valid_o, large_o, rev_o, crc_o}, 0);
    while (!done_o && n < 5000) begin
      start_i = (n == mid_start);
      @(negedge clk);
      n++;
    end
    start_i = 1'b0;
    // R8 / R9: done timing unaffected by a start while busy
    check(n == e_cyc, (mid_start >= 0) ? "R9" : "R8", {name, " latency"}, n, e_cyc);
    check(valid_o == e_valid, tag, {name, " valid"}, valid_o, e_valid);
    check(large_o == e_large, tag, {name, " large"}, large_o, e_large);
    check(rev_o == e_rev, tag, {name, " rev"}, rev_o, e_rev);
    check(crc_o == e_crc, "R3/R7", {name, " crc"}, crc_o, e_crc);
    check(order_err == 0, "R2", {name, " read order"}, order_err, 0);
    @(negedge clk);
    check(!done_o, "R10", {name, " done width"}, done_o, 0);
    repeat (10) @(negedge clk);
    check(valid_o == e_valid && rev_o == e_rev && crc_o == e_crc && !done_o,
          "R10", {name, " hold"}, {valid_o, rev_o, crc_o}, {e_valid, e_rev, e_crc});
  endtask

  task automatic t_reset();
    check(!done_o && !valid_o && !large_o && !rd_req_o, "R1", "reset flags",
          {done_o, valid_o, large_o, rd_req_o}, 0);
    check(rev_o == 0 && crc_o == 0, "R1", "reset values", {rev_o, crc_o}, 0);
  endtask

  task automatic t_short_good();
    fill(16'h1234);
    seal_short(8'h03);
    run_image("short_good", 0, -1);
  endtask

  task automatic t_short_slow();
    fill(16'hA5C3);
    seal_short(8'h02);
    run_image("short_slow", 2, -1);
  endtask

  task automatic t_long_good();
    fill(16'h0F0F);
    mem[SW-1][7:0] = 8'h77;
    seal_long(8'h08);
    run_image("long_good", 0, -1);
  endtask

  task automatic t_both_bad();
    fill(16'h5555);
    seal_short(8'h01);
    mem[LW-1][15:8] = ref_crc(LW) ^ 8'h01;
    mem[5] = mem[5] ^ 16'h0040;
    run_image("both_bad", 1, -1);
  endtask

  task automatic t_all_ff();
    for (int k = 0; k < 256; k++) mem[k] = 16'hFFFF;
    run_image("all_ff", 0, -1);
  endtask

  task automatic t_busy_start();
    fill(16'h3C3C);
    seal_short(8'h04);
    run_image("busy_start", 0, 50);
    fill(16'h6B6B);
    seal_long(8'h05);
    run_image("busy_start_long", 0, 400);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R8 watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    start_i = 1'b0;
    mem_lat = 0;
    order_err = 0;
    exp_addr = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_short_good();
    t_short_slow();
    t_long_good();
    t_both_bad();
    t_all_ff();
    t_busy_start();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule